// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a processor's instruction pipeline and carries out the two control transfers around an interrupt handler. It watches a level-sensitive maskable request, which counts only while the internal enable flag is set, and a non-maskable request, which counts on its rising edge whatever the enable flag holds. When it accepts a maskable request it runs a one-cycle acknowledge, in which the interrupting device returns an 8-bit type. A software-interrupt command brings its own type and goes through the same path. A non-maskable entry always uses type 2.

On entry the sequencer saves the current flags word, code segment and instruction pointer on a downward-growing stack through a 16-bit memory port, and then clears the enable flag. It reads the handler's offset and segment from the vector table at the bottom of memory, at byte address type×4. It then gives the pipeline a one-cycle redirect. The return command reads the three words back in the opposite order, restores the enable flag from the saved flags word, and redirects to the interrupted code with the restored flags. Set-enable and clear-enable commands control the flag directly. Instruction decode and the datapath lie outside this block. The datapath must hold `cur_ip`, `cur_cs` and `cur_flags` valid in the cycle in which an entry starts.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle (`busy_o`=0), the enable flag is 0, `sp_o` equals `SP_INIT` (default 0xF000), and `mem_req`, `ack_o` and `redirect_o` are low.
- R2: `sti_cmd` sets the enable flag and `cli_cmd` clears it (seen on `ie_o` one cycle later). While the flag is 0, a held `intr_req` produces no acknowledge and no activity.
- R3: While the flag is 1 and the block is idle, `intr_req` starts exactly one `ack_o` cycle. The type is taken from `ack_type_i` in that cycle.
- R4: Entry writes three words: the flags word at `sp`-2, `cur_cs` at `sp`-4, and `cur_ip` at `sp`-6, and leaves `sp_o` 6 lower. Bit 9 of the pushed flags word holds the enable flag as it was before entry, and the other bits come from `cur_flags`.
- R5: The enable flag is 0 after every entry.
- R6: The handler offset is the 16-bit word at byte address type×4 and the handler segment is the word at type×4+2. They appear on `redir_ip`/`redir_cs` during a single `redirect_o` cycle, with `flags_load_o`=0. Types 0 and 255 use addresses 0 and 1020.
- R7: A rising edge of `nmi_req` starts an entry with type 2 and no acknowledge, whatever the enable flag holds. A level held high does not start a second entry. An edge that arrives while the block is busy is kept and served once the block is idle.
- R8: When a non-maskable edge and an enabled maskable request are both present in an idle cycle, the non-maskable entry is taken.
- R9: `swi_valid` starts an entry with type `swi_type` and no acknowledge, and it behaves like any other entry.
- R10: `iret_cmd` reads the instruction pointer at `sp`, the code segment at `sp`+2 and the flags word at `sp`+4, and leaves `sp_o` 6 higher. It restores the enable flag from bit 9 of the flags word. It redirects with `flags_load_o`=1 and `redir_flags` set to the flags word.
- R11: Commands are taken only while idle, in the order non-maskable, maskable, software interrupt, return, set-enable, clear-enable. A command given while busy has no effect.
- R12: The memory port returns read data on `mem_rdata` in the cycle after the read request. Byte addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intr_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, edge |
| ack_type_i | input | 8 | Type returned by the device during `ack_o` |
| swi_valid | input | 1 | Software-interrupt command |
| swi_type | input | 8 | Type of the software interrupt |
| iret_cmd | input | 1 | Return-from-interrupt command |
| sti_cmd | input | 1 | Set the enable flag |
| cli_cmd | input | 1 | Clear the enable flag |
| cur_ip | input | 16 | Instruction pointer to save |
| cur_cs | input | 16 | Code segment to save |
| cur_flags | input | 16 | Flags word to save (bit 9 replaced) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after request |
| ack_o | output | 1 | Acknowledge cycle |
| busy_o | output | 1 | Sequence in progress |
| ie_o | output | 1 | Enable flag |
| sp_o | output | ADDR_W | Stack pointer |
| redirect_o | output | 1 | One-cycle jump strobe |
| redir_ip | output | 16 | Target instruction pointer |
| redir_cs | output | 16 | Target code segment |
| flags_load_o | output | 1 | With `redirect_o`: load `redir_flags` |
| redir_flags | output | 16 | Restored flags word |

## Verification
The hardest case to reach is a non-maskable edge that arrives in the middle of a software entry. The edge has to be stored and served only once the first redirect has finished. The bench places the pulse two cycles into a running sequence and expects a second, type 2 redirect right behind the first. It reaches the same-cycle arbitration in a similar way. It holds the maskable line high with the flag set and fires the non-maskable edge in that same idle cycle. It then checks that no acknowledge appears. Random rounds mix the three entry sources with returns, and the nesting grows to four levels, so the pushed flags carry both values of the enable bit.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int unsigned WORD_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP, S_RD_OFF, S_RD_SEG,
    S_GET_SEG, S_POP_IP, S_POP_CS, S_POP_FL, S_GET_FL, S_REDIR
  } seq_state_e;

  typedef struct packed {
    logic take_nmi;
    logic take_intr;
    logic take_swi;
    logic take_ret;
    logic take_sti;
    logic take_cli;
  } arb_grant_t;

  // byte offset of a vector slot inside the table
  function automatic logic [9:0] vec_slot(input logic [7:0] t);
    return {t, 2'b00};
  endfunction

  // flags word as saved: enable bit substituted into the datapath flags
  function automatic logic [WORD_W-1:0] merge_ie(input logic [WORD_W-1:0] fl,
                                                 input logic ie,
                                                 input int unsigned pos);
    logic [WORD_W-1:0] r;
    r      = fl;
    r[pos] = ie;
    return r;
  endfunction

endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_i,
  input  logic       ie_i,
  input  logic       nmi_req,
  input  logic       intr_req,
  input  logic       swi_valid,
  input  logic       iret_cmd,
  input  logic       sti_cmd,
  input  logic       cli_cmd,
  output arb_grant_t grant_o
);

  logic nmi_q, nmi_pend_q;
  logic nmi_edge, nmi_want;

  assign nmi_edge = nmi_req & ~nmi_q;
  assign nmi_want = nmi_edge | nmi_pend_q;

  always_comb begin
    grant_o = '0;
    if (idle_i) begin
      if (nmi_want)             grant_o.take_nmi  = 1'b1;
      else if (intr_req && ie_i) grant_o.take_intr = 1'b1;
      else if (swi_valid)       grant_o.take_swi  = 1'b1;
      else if (iret_cmd)        grant_o.take_ret  = 1'b1;
      else if (sti_cmd)         grant_o.take_sti  = 1'b1;
      else if (cli_cmd)         grant_o.take_cli  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q      <= nmi_req;
      nmi_pend_q <= nmi_want & ~grant_o.take_nmi;
    end
  end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = ADDR_W'(16'hF000),
  parameter int unsigned      IE_BIT   = 9,
  parameter logic [7:0]       NMI_TYPE = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  arb_grant_t        grant_i,
  input  logic [7:0]        swi_type,
  input  logic [7:0]        ack_type_i,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic [WORD_W-1:0] cur_cs,
  input  logic [WORD_W-1:0] cur_flags,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              idle_o,
  output logic              ie_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              ack_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              redirect_o,
  output logic [WORD_W-1:0] redir_ip,
  output logic [WORD_W-1:0] redir_cs,
  output logic              flags_load_o,
  output logic [WORD_W-1:0] redir_flags,
  output logic              push_evt,
  output logic              pop_evt
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  seq_state_e        state_q;
  logic              ie_q, is_ret_q;
  logic [ADDR_W-1:0] sp_q;
  logic [7:0]        vtype_q;
  logic [WORD_W-1:0] sv_ip_q, sv_cs_q, sv_fl_q;
  logic [WORD_W-1:0] tgt_ip_q, tgt_cs_q, tgt_fl_q;
  logic [ADDR_W-1:0] vec_base;

  assign vec_base = ADDR_W'(vec_slot(vtype_q));

  assign push_evt = (state_q == S_PUSH_FL) || (state_q == S_PUSH_CS) ||
                    (state_q == S_PUSH_IP);
  assign pop_evt  = (state_q == S_POP_IP) || (state_q == S_POP_CS) ||
                    (state_q == S_POP_FL);

  always_comb begin
    mem_req   = push_evt || pop_evt || (state_q == S_RD_OFF) || (state_q == S_RD_SEG);
    mem_we    = push_evt;
    mem_addr  = sp_q;
    mem_wdata = sv_ip_q;
    unique case (state_q)
      S_PUSH_FL: begin mem_addr = sp_q - STEP; mem_wdata = sv_fl_q; end
      S_PUSH_CS: begin mem_addr = sp_q - STEP; mem_wdata = sv_cs_q; end
      S_PUSH_IP: begin mem_addr = sp_q - STEP; mem_wdata = sv_ip_q; end
      S_RD_OFF:  mem_addr = vec_base;
      S_RD_SEG:  mem_addr = vec_base + STEP;
      default:   mem_addr = sp_q;
    endcase
  end

  assign idle_o       = (state_q == S_IDLE);
  assign ack_o        = (state_q == S_ACK);
  assign redirect_o   = (state_q == S_REDIR);
  assign flags_load_o = redirect_o && is_ret_q;
  assign redir_ip     = tgt_ip_q;
  assign redir_cs     = tgt_cs_q;
  assign redir_flags  = tgt_fl_q;
  assign ie_o         = ie_q;
  assign sp_o         = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ie_q     <= 1'b0;
      is_ret_q <= 1'b0;
      sp_q     <= SP_INIT;
      vtype_q  <= '0;
      sv_ip_q  <= '0;
      sv_cs_q  <= '0;
      sv_fl_q  <= '0;
      tgt_ip_q <= '0;
      tgt_cs_q <= '0;
      tgt_fl_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (grant_i.take_nmi || grant_i.take_intr || grant_i.take_swi) begin
            sv_ip_q  <= cur_ip;
            sv_cs_q  <= cur_cs;
            sv_fl_q  <= merge_ie(cur_flags, ie_q, IE_BIT);
            is_ret_q <= 1'b0;
          end
          if (grant_i.take_nmi) begin
            vtype_q <= NMI_TYPE;
            state_q <= S_PUSH_FL;
          end else if (grant_i.take_intr) begin
            state_q <= S_ACK;
          end else if (grant_i.take_swi) begin
            vtype_q <= swi_type;
            state_q <= S_PUSH_FL;
          end else if (grant_i.take_ret) begin
            is_ret_q <= 1'b1;
            state_q  <= S_POP_IP;
          end else if (grant_i.take_sti) begin
            ie_q <= 1'b1;
          end else if (grant_i.take_cli) begin
            ie_q <= 1'b0;
          end
        end
        S_ACK: begin
          vtype_q <= ack_type_i;
          state_q <= S_PUSH_FL;
        end
        S_PUSH_FL: begin sp_q <= sp_q - STEP; ie_q <= 1'b0; state_q <= S_PUSH_CS; end
        S_PUSH_CS: begin sp_q <= sp_q - STEP; state_q <= S_PUSH_IP; end
        S_PUSH_IP: begin sp_q <= sp_q - STEP; state_q <= S_RD_OFF; end
        S_RD_OFF:  state_q <= S_RD_SEG;
        S_RD_SEG:  begin tgt_ip_q <= mem_rdata; state_q <= S_GET_SEG; end
        S_GET_SEG: begin tgt_cs_q <= mem_rdata; state_q <= S_REDIR; end
        S_POP_IP:  begin sp_q <= sp_q + STEP; state_q <= S_POP_CS; end
        S_POP_CS:  begin sp_q <= sp_q + STEP; tgt_ip_q <= mem_rdata; state_q <= S_POP_FL; end
        S_POP_FL:  begin sp_q <= sp_q + STEP; tgt_cs_q <= mem_rdata; state_q <= S_GET_FL; end
        S_GET_FL: begin
          tgt_fl_q <= mem_rdata;
          ie_q     <= mem_rdata[IE_BIT];
          state_q  <= S_REDIR;
        end
        S_REDIR:   state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = ADDR_W'(16'hF000),
  parameter int unsigned      IE_BIT   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intr_req,
  input  logic              nmi_req,
  input  logic [7:0]        ack_type_i,
  input  logic              swi_valid,
  input  logic [7:0]        swi_type,
  input  logic              iret_cmd,
  input  logic              sti_cmd,
  input  logic              cli_cmd,
  input  logic [15:0]       cur_ip,
  input  logic [15:0]       cur_cs,
  input  logic [15:0]       cur_flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              ack_o,
  output logic              busy_o,
  output logic              ie_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              redirect_o,
  output logic [15:0]       redir_ip,
  output logic [15:0]       redir_cs,
  output logic              flags_load_o,
  output logic [15:0]       redir_flags
);

  arb_grant_t grant_w;
  logic       idle_w;
  logic       take_nmi_w, take_intr_w, push_evt_w, pop_evt_w;

  assign busy_o      = ~idle_w;
  assign take_nmi_w  = grant_w.take_nmi;
  assign take_intr_w = grant_w.take_intr;

  irq_src_arb arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle_w),
    .ie_i      (ie_o),
    .nmi_req   (nmi_req),
    .intr_req  (intr_req),
    .swi_valid (swi_valid),
    .iret_cmd  (iret_cmd),
    .sti_cmd   (sti_cmd),
    .cli_cmd   (cli_cmd),
    .grant_o   (grant_w)
  );

  irq_stack_seq #(
    .ADDR_W  (ADDR_W),
    .SP_INIT (SP_INIT),
    .IE_BIT  (IE_BIT)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_i      (grant_w),
    .swi_type     (swi_type),
    .ack_type_i   (ack_type_i),
    .cur_ip       (cur_ip),
    .cur_cs       (cur_cs),
    .cur_flags    (cur_flags),
    .mem_rdata    (mem_rdata),
    .idle_o       (idle_w),
    .ie_o         (ie_o),
    .sp_o         (sp_o),
    .ack_o        (ack_o),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .redirect_o   (redirect_o),
    .redir_ip     (redir_ip),
    .redir_cs     (redir_cs),
    .flags_load_o (flags_load_o),
    .redir_flags  (redir_flags),
    .push_evt     (push_evt_w),
    .pop_evt      (pop_evt_w)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ie_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              busy_o,
  input logic              ack_o,
  input logic              mem_req,
  input logic              mem_we,
  input logic              redirect_o,
  input logic              flags_load_o,
  input logic              take_nmi,
  input logic              take_intr,
  input logic              push_evt,
  input logic              pop_evt
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req && !ack_o));

  // R2
  masked_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr |-> ie_o);

  // R3
  ack_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (mem_req && mem_we));

  // R4
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (sp_o == $past(sp_o) - ADDR_W'(2)));

  // R5
  entry_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !flags_load_o) |-> !ie_o);

  // R8
  nmi_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> !ack_o);

  // R10
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (sp_o == $past(sp_o) + ADDR_W'(2)));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, redirect_o, mem_req}));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ie_o         (ie_o),
  .sp_o         (sp_o),
  .busy_o       (busy_o),
  .ack_o        (ack_o),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .redirect_o   (redirect_o),
  .flags_load_o (flags_load_o),
  .take_nmi     (take_nmi_w),
  .take_intr    (take_intr_w),
  .push_evt     (push_evt_w),
  .pop_evt      (pop_evt_w)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;

  localparam logic [15:0] SP0 = 16'hF000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        intr_req = 0, nmi_req = 0, swi_valid = 0, iret_cmd = 0, sti_cmd = 0, cli_cmd = 0;
  logic [7:0]  ack_type_i = 0, swi_type = 0;
  logic [15:0] cur_ip = 0, cur_cs = 0, cur_flags = 0;
  logic        mem_req, mem_we, ack_o, busy_o, ie_o, redirect_o, flags_load_o;
  logic [15:0] mem_addr, mem_wdata, sp_o, redir_ip, redir_cs, redir_flags;
  logic [15:0] mem_rdata = 0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .nmi_req(nmi_req),
    .ack_type_i(ack_type_i), .swi_valid(swi_valid), .swi_type(swi_type),
    .iret_cmd(iret_cmd), .sti_cmd(sti_cmd), .cli_cmd(cli_cmd),
    .cur_ip(cur_ip), .cur_cs(cur_cs), .cur_flags(cur_flags),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ack_o(ack_o), .busy_o(busy_o), .ie_o(ie_o), .sp_o(sp_o),
    .redirect_o(redirect_o), .redir_ip(redir_ip), .redir_cs(redir_cs),
    .flags_load_o(flags_load_o), .redir_flags(redir_flags)
  );

  // word memory, read data one cycle after request (R12)
  logic [15:0] mem_q [int unsigned];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem_q[int'(mem_addr >> 1)] = mem_wdata;
      else mem_rdata <= mem_q.exists(int'(mem_addr >> 1)) ? mem_q[int'(mem_addr >> 1)] : 16'h0;
    end
  end

  function automatic logic [15:0] vo(input logic [7:0] t);
    return (16'(t) * 16'd37) ^ 16'h5A00;
  endfunction
  function automatic logic [15:0] vs(input logic [7:0] t);
    return {~t, t};
  endfunction
  function automatic logic [15:0] pushed_fl(input logic [15:0] f, input logic ie);
    return ie ? (f | 16'h0200) : (f & 16'hFDFF);
  endfunction
  function automatic logic [15:0] rdm(input logic [15:0] byte_addr);
    return mem_q.exists(int'(byte_addr >> 1)) ? mem_q[int'(byte_addr >> 1)] : 16'hDEAD;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // waits for the redirect strobe; pulse commands are released after one cycle
  logic [15:0] r_ip, r_cs, r_fl;
  logic        r_ld;
  int          r_acks;
  task automatic wait_redir(input bit keep_nmi);
    bit found = 0;
    r_acks = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      swi_valid = 0; iret_cmd = 0; sti_cmd = 0; cli_cmd = 0;
      if (!keep_nmi) nmi_req = 0;
      if (ack_o) r_acks++;
      if (redirect_o) begin
        r_ip = redir_ip; r_cs = redir_cs; r_fl = redir_flags; r_ld = flags_load_o;
        found = 1;
        break;
      end
    end
    if (!found) chk("R6", "redirect seen", 0, 1);
    intr_req = 0;
    @(negedge clk);
  endtask

  // model state
  logic [15:0] sp_m;
  logic        ie_m;
  logic [15:0] st_ip[$], st_cs[$], st_fl[$];

  task automatic check_entry(input string req, input logic [7:0] t, input int exp_acks);
    logic [15:0] fl;
    fl = st_fl[$];
    chk(req, "redir_ip", r_ip, vo(t));
    chk(req, "redir_cs", r_cs, vs(t));
    chk(req, "flags_load", r_ld, 0);
    chk("R3", "ack count", r_acks, exp_acks);
    chk("R4", "pushed flags", rdm(sp_m + 16'd4), fl);
    chk("R4", "pushed cs", rdm(sp_m + 16'd2), st_cs[$]);
    chk("R4", "pushed ip", rdm(sp_m), st_ip[$]);
    chk("R4", "sp after entry", sp_o, sp_m);
    chk("R5", "ie after entry", ie_o, 0);
  endtask

  task automatic start_frame(input logic [15:0] ip, input logic [15:0] cs, input logic [15:0] f);
    cur_ip = ip; cur_cs = cs; cur_flags = f;
    st_ip.push_back(ip); st_cs.push_back(cs); st_fl.push_back(pushed_fl(f, ie_m));
    sp_m = sp_m - 16'd6;
    ie_m = 0;
  endtask

  task automatic pulse_sti();
    @(negedge clk); sti_cmd = 1;
    @(negedge clk); sti_cmd = 0;
    ie_m = 1;
  endtask

  task automatic do_iret();
    logic [15:0] ip, cs, fl;
    ip = st_ip.pop_back(); cs = st_cs.pop_back(); fl = st_fl.pop_back();
    iret_cmd = 1;
    wait_redir(0);
    sp_m = sp_m + 16'd6;
    ie_m = fl[9];
    chk("R10", "ret ip", r_ip, ip);
    chk("R10", "ret cs", r_cs, cs);
    chk("R10", "ret flags", r_fl, fl);
    chk("R10", "flags_load", r_ld, 1);
    chk("R10", "sp after ret", sp_o, sp_m);
    chk("R10", "ie restored", ie_o, ie_m);
  endtask

  task automatic fire_swi(input logic [7:0] t);
    start_frame(16'($urandom), 16'($urandom), 16'($urandom));
    swi_type = t; swi_valid = 1;
    wait_redir(0);
    check_entry("R9", t, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'd4242));
    for (int t = 0; t < 256; t++) begin
      mem_q[t * 2]     = vo(8'(t));
      mem_q[t * 2 + 1] = vs(8'(t));
    end
    sp_m = SP0; ie_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "ie", ie_o, 0);
    chk("R1", "sp", sp_o, SP0);
    chk("R1", "mem_req/ack/redirect", {mem_req, ack_o, redirect_o}, 0);

    // R2: masked request ignored
    intr_req = 1; ack_type_i = 8'h40; seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (ack_o || busy_o) seen++; end
    chk("R2", "masked intr activity", seen, 0);
    intr_req = 0;
    pulse_sti();
    chk("R2", "ie after sti", ie_o, 1);
    @(negedge clk); cli_cmd = 1; @(negedge clk); cli_cmd = 0; ie_m = 0;
    chk("R2", "ie after cli", ie_o, 0);

    // random mix of entries and returns
    for (int n = 0; n < 40; n++) begin
      int kind;
      logic [7:0] t;
      kind = int'($urandom % 4);
      if (st_ip.size() >= 4 || (kind == 3 && st_ip.size() > 0)) begin
        if ($urandom % 2) pulse_sti();
        do_iret();
      end else if (kind == 0 || kind == 3) begin
        if (!ie_m) pulse_sti();
        t = 8'($urandom);
        ack_type_i = t;
        start_frame(16'($urandom), 16'($urandom), 16'($urandom));
        intr_req = 1;
        wait_redir(0);
        check_entry("R3", t, 1);
      end else if (kind == 1) begin
        fire_swi(8'($urandom));
      end else begin
        start_frame(16'($urandom), 16'($urandom), 16'($urandom));
        nmi_req = 1;
        wait_redir(0);
        check_entry("R7", 8'd2, 0);
      end
    end
    while (st_ip.size() > 0) do_iret();

    // R6 boundary types 0 and 255
    fire_swi(8'd0);
    fire_swi(8'd255);
    do_iret(); do_iret();

    // R8: NMI and enabled maskable request in the same cycle
    pulse_sti();
    ack_type_i = 8'h33;
    start_frame(16'h1111, 16'h2222, 16'h0000);
    intr_req = 1; nmi_req = 1;
    wait_redir(0);
    check_entry("R8", 8'd2, 0);
    intr_req = 1; seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (ack_o || busy_o) seen++; end
    chk("R8", "intr after nmi entry (ie=0)", seen, 0);
    intr_req = 0;
    do_iret();

    // R7: held level does not retrigger
    start_frame(16'h3333, 16'h4444, 16'h0001);
    nmi_req = 1;
    wait_redir(1);
    check_entry("R7", 8'd2, 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy_o) seen++; end
    chk("R7", "held nmi retrigger", seen, 0);
    nmi_req = 0;
    do_iret();

    // R7: edge during a busy software entry is served afterwards
    start_frame(16'h5555, 16'h6666, 16'h0002);
    swi_type = 8'h21; swi_valid = 1;
    @(negedge clk); swi_valid = 0;
    @(negedge clk); nmi_req = 1;
    @(negedge clk); nmi_req = 0;
    wait_redir(0);
    check_entry("R9", 8'h21, 0);
    start_frame(16'h5555, 16'h6666, 16'h0002);
    st_ip[$] = redir_ip; st_cs[$] = redir_cs; st_fl[$] = pushed_fl(16'h0002, 1'b0);
    cur_ip = redir_ip; cur_cs = redir_cs;
    wait_redir(0);
    chk("R7", "deferred nmi ip", r_ip, vo(8'd2));
    chk("R7", "deferred nmi cs", r_cs, vs(8'd2));
    chk("R7", "sp after deferred nmi", sp_o, sp_m);
    do_iret(); do_iret();

    // R11: set-enable while busy has no effect; swi beats iret
    ie_m = ie_o;
    start_frame(16'h7777, 16'h8888, 16'h0000);
    swi_type = 8'h10; swi_valid = 1; iret_cmd = 1;
    @(negedge clk); swi_valid = 0; iret_cmd = 0;
    @(negedge clk); @(negedge clk); sti_cmd = 1;
    @(negedge clk); sti_cmd = 0;
    wait_redir(0);
    check_entry("R11", 8'h10, 0);
    chk("R11", "sti while busy ignored", ie_o, 0);
    do_iret();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule